// File: doc/BRIEF.md
# Rotating binary-group unit selector

The block turns an N-bit binary sample into control lines for 2^N-1 identical unit elements. Every code bit owns a contiguous group of units whose size is that bit's weight. Bit 0 owns one unit, bit 1 owns two, and so on. Before the groups are applied to the output, the whole pattern is rotated circularly by a step count that is drawn again for every sample. A given code value therefore lights a different set of physical units on successive samples, but always the same number of them. No binary-to-thermometer decoder is used.

The step count comes from an on-chip linear feedback shift register. It reaches the pattern through a logarithmic rotator, which has one conditional-shift stage per bit of the step. The result is registered. When the randomization enable is low, the step is held at zero and the block gives the plain fixed binary grouping.

Top module: `rrbs_selector`

## Requirements
- R1: Unit line index i runs from 0 (unit 1) to 2^N-2. With no rotation, code bit k drives lines 2^k-1 through 2^(k+1)-2. For N=3 this gives line 0 from bit 0, lines 1..2 from bit 1 and lines 3..6 from bit 2.
- R2: `unit_o` is a register. It shows the mapping of `code_i`, `rand_en_i` and the step that were present at the previous rising clock edge. While reset is active it is all zeros.
- R3: The number of ones in `unit_o` always equals the code value sampled one edge earlier. Code 0 gives no active line and the full-scale code gives all lines active.
- R4: When `rand_en_i` is low at the sampling edge, the step is 0 and the output is the fixed mapping of R1.
- R5: When `rand_en_i` is high, the step R is the low N bits of the generator state. Line j of the output takes the unrotated value of line (j+R) mod (2^N-1), which is a right rotation. For N=3: with R=4, bit 0 lands on line 3, and with R=5 it lands on line 2.
- R6: The generator is 15 bits wide and loads `LFSR_SEED` (default 1) on reset. It advances on every clock after reset, whatever the enable, to {s[13:0], s[14]^s[13]}. If its state is zero, the next state is forced to 1.
- R7: A step equal to the line count (7 for N=3) acts as a step of 0, because rotation is taken modulo the number of lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rand_en_i | input | 1 | High: rotate by the random step. Low: use the fixed grouping |
| code_i | input | CODE_W | Binary sample code |
| unit_o | output | 2^CODE_W-1 | Registered unit element controls, line 0 = unit 1 |

## Verification
Two functions can coincide in one cycle. In the first, the generator produces the wrap-around step equal to the line count while the counting rule still has to hold. The bench runs an independent model of the generator until that step appears, then checks both the identity mapping and the count in that cycle. In the second, the enable is toggled every sample while the generator keeps producing nonzero steps. Each low-enable sample must show the fixed grouping exactly, and the sample after it must resume the random sequence with no missed generator step.

// File: rtl/rrbs_pkg.sv
package rrbs_pkg;
  function automatic int unsigned unit_count(input int unsigned code_w);
    return (32'd1 << code_w) - 32'd1;
  endfunction

  localparam int unsigned GEN_W_DEF    = 15;
  localparam logic [14:0] GEN_TAPS_DEF = 15'h6000;
endpackage

// File: rtl/rrbs_group_map.sv
// Expands each code bit onto its binary-weighted run of unit lines.
module rrbs_group_map #(
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned N_UNITS = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [N_UNITS-1:0] pat_o
);
  for (genvar k = 0; k < CODE_W; k++) begin : g_bit
    localparam int unsigned BASE = (1 << k) - 1;
    for (genvar j = 0; j < (1 << k); j++) begin : g_line
      assign pat_o[BASE+j] = code_i[k];
    end
  end
endmodule

// File: rtl/rrbs_rotator.sv
// Logarithmic circular rotator: stage s shifts by 2^s mod N when step bit s is set.
module rrbs_rotator #(
  parameter int unsigned N_UNITS = 7,
  parameter int unsigned ROT_W   = 3
) (
  input  logic [N_UNITS-1:0] vec_i,
  input  logic [ROT_W-1:0]   step_i,
  output logic [N_UNITS-1:0] vec_o
);
  logic [ROT_W:0][N_UNITS-1:0] stage;

  assign stage[0] = vec_i;

  for (genvar s = 0; s < ROT_W; s++) begin : g_stage
    localparam int unsigned SH = (1 << s) % N_UNITS;
    for (genvar j = 0; j < N_UNITS; j++) begin : g_mux
      assign stage[s+1][j] = step_i[s] ? stage[s][(j + SH) % N_UNITS] : stage[s][j];
    end
  end

  assign vec_o = stage[ROT_W];
endmodule

// File: rtl/rrbs_lfsr.sv
// Free-running step generator with all-zero escape.
module rrbs_lfsr #(
  parameter int unsigned     GEN_W = 15,
  parameter logic [GEN_W-1:0] TAPS = 15'h6000,
  parameter logic [GEN_W-1:0] SEED = 15'h0001,
  parameter int unsigned     OUT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);
  logic [GEN_W-1:0] state_q, state_d;
  logic             fb;

  assign fb = ^(state_q & TAPS);

  always_comb begin
    if (state_q == '0) state_d = GEN_W'(1);
    else               state_d = {state_q[GEN_W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign rnd_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/rrbs_selector.sv
module rrbs_selector
  import rrbs_pkg::*;
#(
  parameter int unsigned      CODE_W    = 3,
  parameter int unsigned      GEN_W     = GEN_W_DEF,
  parameter logic [GEN_W-1:0] GEN_TAPS  = GEN_TAPS_DEF,
  parameter logic [GEN_W-1:0] LFSR_SEED = 15'h0001,
  localparam int unsigned     N_UNITS   = unit_count(CODE_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rand_en_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic [N_UNITS-1:0] unit_o
);
  localparam int unsigned ROT_W = CODE_W;

  logic [ROT_W-1:0]   rnd;
  logic [ROT_W-1:0]   step;
  logic [N_UNITS-1:0] pat;
  logic [N_UNITS-1:0] rot_vec;
  logic [N_UNITS-1:0] unit_q;

  rrbs_lfsr #(
    .GEN_W (GEN_W),
    .TAPS  (GEN_TAPS),
    .SEED  (LFSR_SEED),
    .OUT_W (ROT_W)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd)
  );

  assign step = rand_en_i ? rnd : '0;

  rrbs_group_map #(
    .CODE_W  (CODE_W),
    .N_UNITS (N_UNITS)
  ) u_map (
    .code_i (code_i),
    .pat_o  (pat)
  );

  rrbs_rotator #(
    .N_UNITS (N_UNITS),
    .ROT_W   (ROT_W)
  ) u_rot (
    .vec_i  (pat),
    .step_i (step),
    .vec_o  (rot_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unit_q <= '0;
    else         unit_q <= rot_vec;
  end

  assign unit_o = unit_q;
endmodule

// File: rtl/rrbs_selector_chk.sv
module rrbs_selector_chk #(
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned N_UNITS = (1 << CODE_W) - 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rand_en_i,
  input logic [CODE_W-1:0]  code_i,
  input logic [N_UNITS-1:0] unit_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ($countones(unit_o) == int'($past(code_i)))) // R3
    else $error("active unit count differs from code");

  AST_ZERO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(code_i) == '0) |-> (unit_o == '0)) // R3
    else $error("zero code drove a unit");

  AST_FULL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(code_i) == {CODE_W{1'b1}}) |-> (unit_o == {N_UNITS{1'b1}})) // R3
    else $error("full code left a unit idle");

  AST_FIXED_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(rand_en_i)) |-> (unit_o[0] == $past(code_i[0]))) // R4
    else $error("fixed mapping lost bit 0 position");

  AST_FIXED_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(rand_en_i)) |-> (unit_o[N_UNITS-1] == $past(code_i[CODE_W-1]))) // R1
    else $error("fixed mapping lost top bit position");

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (unit_o == '0) else $error("reset output"); // R2
  end
endmodule

bind rrbs_selector rrbs_selector_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rand_en_i (rand_en_i),
  .code_i    (code_i),
  .unit_o    (unit_o)
);

// File: tb/rrbs_selector_tb.sv
module rrbs_selector_tb;
  localparam int CODE_W = 3;
  localparam int N      = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [2:0]   code = '0;
  logic [N-1:0] u_a, u_z;
  logic [14:0]  m_a, m_z;
  logic [N-1:0] last_a = '0;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rrbs_selector #(.CODE_W(CODE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rand_en_i(en), .code_i(code), .unit_o(u_a));

  rrbs_selector #(.CODE_W(CODE_W), .LFSR_SEED(15'h0000)) u_dut_zero (
    .clk_i(clk), .rst_ni(rst_n), .rand_en_i(en), .code_i(code), .unit_o(u_z));

  // R6 generator model
  function automatic logic [14:0] gen_next(input logic [14:0] s);
    if (s == '0) return 15'h0001;
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_a <= 15'h0001;
      m_z <= 15'h0000;
    end else begin
      m_a <= gen_next(m_a);
      m_z <= gen_next(m_z);
    end
  end

  // R1 grouping then R5 right rotation modulo N
  function automatic logic [N-1:0] exp_vec(input logic [2:0] c, input int r);
    logic [N-1:0] p, o;
    for (int k = 0; k < CODE_W; k++)
      for (int i = (1 << k) - 1; i <= (1 << (k + 1)) - 2; i++) p[i] = c[k];
    for (int j = 0; j < N; j++) o[j] = p[(j + r) % N];
    return o;
  endfunction

  task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input string req, input logic [2:0] c, input logic e, output int r_used);
    logic [N-1:0] ea, ez;
    code = c;
    en   = e;
    #1;
    check_vec("R2 latency", u_a, last_a);
    r_used = e ? int'(m_a[2:0]) : 0;
    ea = exp_vec(c, r_used);
    ez = exp_vec(c, e ? int'(m_z[2:0]) : 0);
    @(posedge clk);
    @(negedge clk);
    check_vec(req, u_a, ea);
    check_vec({req, " zero-seed"}, u_z, ez);
    check_int("R3 count", $countones(u_a), int'(c));
    last_a = ea;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_vec("R2 reset", u_a, '0);
    check_vec("R2 reset zero-seed", u_z, '0);
    rst_n  = 1'b1;
    last_a = '0;
  endtask

  task automatic t_lockup;
    int r;
    step("R6", 3'd6, 1'b1, r);
    check_vec("R6 escape step0", u_z, 7'b1111110);
    step("R6", 3'd6, 1'b1, r);
    check_vec("R6 escape step1", u_z, 7'b0111111);
  endtask

  task automatic t_fixed;
    int r;
    for (int c = 0; c < 8; c++) step("R1/R4", 3'(c), 1'b0, r);
    step("R1", 3'd4, 1'b0, r);
    check_vec("R1 bit2 group", u_a, 7'b1111000);
    step("R1", 3'd2, 1'b0, r);
    check_vec("R1 bit1 group", u_a, 7'b0000110);
  endtask

  task automatic t_random;
    int r;
    for (int i = 0; i < 80; i++) step("R5", 3'((i * 5 + 3) % 8), 1'b1, r);
    step("R3", 3'd0, 1'b1, r);
    check_vec("R3 zero code", u_a, '0);
    step("R3", 3'd7, 1'b1, r);
    check_vec("R3 full code", u_a, '1);
  endtask

  task automatic t_toggle;
    int r;
    for (int i = 0; i < 24; i++) step("R4", 3'((i * 3 + 1) % 8), 1'(i % 2), r);
  endtask

  task automatic t_wrap;
    int r;
    bit seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      step("R5", 3'd1, 1'b1, r);
      if (r == 7) begin
        seen = 1;
        check_vec("R7 wrap equals fixed", u_a, 7'b0000001);
      end
    end
    check_int("R7 wrap step reached", int'(seen), 1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    t_reset();
    t_lockup();
    t_fixed();
    t_random();
    t_toggle();
    t_wrap();
    t_reset();
    finish_run();
  end
endmodule